// File: doc/BRIEF.md
# Multi-Cycle Phase Tracking Detector

This block sits between a reference/feedback edge detector and a DPLL loop filter. It runs in a fast system clock domain and receives one-cycle strobes marking each reference edge and each feedback edge. It also receives a signed sub-cycle phase value from a fine phase detector. From these it produces a signed phase error for the loop filter. When multi-cycle tracking is enabled, the block keeps a signed count of whole cycles that the reference is ahead of (or behind) the feedback clock. This count covers a programmable window that widens in powers of two, so the loop keeps its phase position through large bursts of input jitter.

With tracking enabled, the loop sees one of two things. It either sees the full remembered phase, which gives fast pull-in with more overshoot, or a copy of it clamped to one unit interval, which gives slower pull-in with less overshoot. In both cases the whole-cycle count keeps being tracked. With tracking disabled, the block is a plain single-cycle detector. Once lock is reported it drops to nearest-edge capture, unless a disable input holds it in the full ±1 UI capture mode. A flag reports when nearest-edge capture is active.

Phase values use a fixed-point format with FRAC_W fraction bits, so one unit interval (UI) equals 2^FRAC_W. The fine phase input has FRAC_W+1 bits in two's complement.

Top module: `mcyc_phase_tracker`

## Requirements
- R1: While reset is applied, `phase_err_o` is 0 and `near_edge_o` and `cyc_ovf_o` are 0.
- R2: With `mc_en_i` = 0, the whole-cycle count is held at 0 and `cyc_ovf_o` stays 0, whatever the edge strobes do.
- R3: The range code k selects a count limit of 2^(k+1)−1 cycles. Codes above CNT_W−2 give the largest limit, 2^(CNT_W−1)−1 (8191 for the default CNT_W = 14).
- R4: With `mc_en_i` = 1, the count rises by one for a reference strobe alone and falls by one for a feedback strobe alone. It does not change when both strobes or neither strobe arrive in the same cycle.
- R5: The count never passes ±limit. A step that would take it past the limit, or a range change that leaves it outside, sets the count to the nearest bound and sets `cyc_ovf_o`. The flag then stays at 1 until `mc_en_i` returns to 0.
- R6: With `mc_en_i` = 1 and `loop_full_i` = 1, `phase_err_o` = count × 2^FRAC_W + fine phase.
- R7: With `mc_en_i` = 1 and `loop_full_i` = 0, `phase_err_o` is that same sum limited to ±2^FRAC_W. The count keeps tracking, so setting `loop_full_i` to 1 shows the full value at once.
- R8: With `mc_en_i` = 0, `locked_i` = 1 and `ne_dis_i` = 0, `near_edge_o` = 1 and the fine phase is folded into ±2^(FRAC_W−1). A value above +2^(FRAC_W−1) loses 2^FRAC_W, and a value below −2^(FRAC_W−1) gains 2^FRAC_W.
- R9: With `ne_dis_i` = 1, `near_edge_o` = 0. With `mc_en_i` = 0, `phase_err_o` then equals the fine phase unchanged, whatever the value of `locked_i`.
- R10: `phase_err_o` and `near_edge_o` are registered. They reflect the inputs and the count one clock after the count register updates, so a strobe reaches `phase_err_o` on the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_edge_i | input | 1 | One-cycle strobe per reference clock edge |
| fb_edge_i | input | 1 | One-cycle strobe per feedback clock edge |
| fine_phase_i | input | FRAC_W+1 | Signed sub-cycle phase from the fine detector, 2^FRAC_W = 1 UI |
| mc_en_i | input | 1 | Enables multi-cycle tracking |
| range_code_i | input | RANGE_W | Tracking range code |
| loop_full_i | input | 1 | 1: full tracked phase to loop; 0: clamp to ±1 UI |
| locked_i | input | 1 | Phase lock reported by the lock detectors |
| ne_dis_i | input | 1 | Forces full ±1 UI capture, blocks nearest-edge mode |
| phase_err_o | output | CNT_W+FRAC_W+1 | Signed phase error to the loop filter |
| near_edge_o | output | 1 | Nearest-edge capture active |
| cyc_ovf_o | output | 1 | Sticky whole-cycle count saturation flag |

## Verification
The checker watches several properties on every cycle:
- the count stays inside the limit decoded one cycle earlier;
- the count holds when the strobes cancel or are absent;
- the overflow flag is sticky while tracking is enabled;
- the count is cleared while tracking is disabled;
- the clamped and nearest-edge outputs stay within their bounds;
- the nearest-edge flag follows the mode inputs.

Some behaviour can only be shown by the bench's sweeps, because it needs exact arithmetic on the outputs. This covers the exact limit for every range code, the full sum count × UI + fine, the folding of each fine value, and a remembered count reappearing when full-loop mode is switched on.

// File: rtl/mcpt_pkg.sv
package mcpt_pkg;

  // Capture behaviour chosen from the enable, lock and override inputs.
  typedef enum logic [1:0] {
    CAP_SINGLE      = 2'd0,
    CAP_NEAREST     = 2'd1,
    CAP_MULTI_FULL  = 2'd2,
    CAP_MULTI_CLAMP = 2'd3
  } cap_mode_e;

endpackage

// File: rtl/mcpt_rst_sync.sv
module mcpt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/mcpt_range_decode.sv
module mcpt_range_decode #(
  parameter int CNT_W   = 14,
  parameter int RANGE_W = 4
) (
  input  logic [RANGE_W-1:0] code_i,
  output logic [CNT_W-1:0]   limit_o
);

  localparam int MAX_CODE = CNT_W - 2;
  localparam int NCODE    = 1 << RANGE_W;

  logic [CNT_W-1:0] lim_tab [NCODE];

  // One limit per code; codes past MAX_CODE saturate at the widest window.
  for (genvar k = 0; k < NCODE; k++) begin : g_code
    localparam int EFF = (k > MAX_CODE) ? MAX_CODE : k;
    assign lim_tab[k] = CNT_W'((64'd1 << (EFF + 1)) - 64'd1);
  end

  assign limit_o = lim_tab[code_i];

endmodule

// File: rtl/mcpt_cycle_counter.sv
module mcpt_cycle_counter #(
  parameter int CNT_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic                    inc_i,
  input  logic                    dec_i,
  input  logic [CNT_W-1:0]        limit_i,
  output logic signed [CNT_W-1:0] cnt_o,
  output logic                    ovf_o
);

  logic signed [CNT_W-1:0] cnt_q, cnt_d;
  logic                    ovf_q, ovf_d;
  logic                    upd_en;
  logic signed [CNT_W:0]   step, sum, lim_pos, lim_neg;

  always_comb begin
    step = '0;
    if (inc_i && !dec_i) begin
      step = (CNT_W+1)'(1);
    end else if (dec_i && !inc_i) begin
      step = '1;
    end
    lim_pos = $signed({1'b0, limit_i});
    lim_neg = -lim_pos;
    sum     = $signed({cnt_q[CNT_W-1], cnt_q}) + step;
    cnt_d   = cnt_q;
    ovf_d   = ovf_q;
    if (!en_i) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (sum > lim_pos) begin
      cnt_d = lim_pos[CNT_W-1:0];
      ovf_d = 1'b1;
    end else if (sum < lim_neg) begin
      cnt_d = lim_neg[CNT_W-1:0];
      ovf_d = 1'b1;
    end else begin
      cnt_d = sum[CNT_W-1:0];
    end
    upd_en = (cnt_d != cnt_q) || (ovf_d != ovf_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

endmodule

// File: rtl/mcpt_mode_sel.sv
module mcpt_mode_sel
  import mcpt_pkg::*;
(
  input  logic      mc_en_i,
  input  logic      loop_full_i,
  input  logic      locked_i,
  input  logic      ne_dis_i,
  output cap_mode_e mode_o
);

  always_comb begin
    if (mc_en_i) begin
      mode_o = loop_full_i ? CAP_MULTI_FULL : CAP_MULTI_CLAMP;
    end else if (locked_i && !ne_dis_i) begin
      mode_o = CAP_NEAREST;
    end else begin
      mode_o = CAP_SINGLE;
    end
  end

endmodule

// File: rtl/mcpt_phase_combine.sv
module mcpt_phase_combine
  import mcpt_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int FRAC_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  cap_mode_e                      mode_i,
  input  logic signed [CNT_W-1:0]        cnt_i,
  input  logic signed [FRAC_W:0]         fine_i,
  output logic signed [CNT_W+FRAC_W:0]   phase_o,
  output logic                           near_o
);

  localparam int OUT_W = CNT_W + FRAC_W + 1;
  localparam logic signed [OUT_W-1:0] UI_P   = OUT_W'(64'd1 << FRAC_W);
  localparam logic signed [OUT_W-1:0] HALF_P = OUT_W'(64'd1 << (FRAC_W - 1));

  logic signed [OUT_W-1:0] fine_x, cnt_x, full_v, wrap_v, clamp_v, phase_d, phase_q;
  logic                    near_d, near_q;

  always_comb begin
    fine_x = {{CNT_W{fine_i[FRAC_W]}}, fine_i};
    cnt_x  = {cnt_i[CNT_W-1], cnt_i, {FRAC_W{1'b0}}};
    full_v = cnt_x + fine_x;

    if (fine_x > HALF_P) begin
      wrap_v = fine_x - UI_P;
    end else if (fine_x < -HALF_P) begin
      wrap_v = fine_x + UI_P;
    end else begin
      wrap_v = fine_x;
    end

    if (full_v > UI_P) begin
      clamp_v = UI_P;
    end else if (full_v < -UI_P) begin
      clamp_v = -UI_P;
    end else begin
      clamp_v = full_v;
    end

    unique case (mode_i)
      CAP_NEAREST:     phase_d = wrap_v;
      CAP_MULTI_FULL:  phase_d = full_v;
      CAP_MULTI_CLAMP: phase_d = clamp_v;
      default:         phase_d = fine_x;
    endcase
    near_d = (mode_i == CAP_NEAREST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      near_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      near_q  <= near_d;
    end
  end

  assign phase_o = phase_q;
  assign near_o  = near_q;

endmodule

// File: rtl/mcyc_phase_tracker.sv
module mcyc_phase_tracker
  import mcpt_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int FRAC_W  = 8,
  parameter int RANGE_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ref_edge_i,
  input  logic                         fb_edge_i,
  input  logic signed [FRAC_W:0]       fine_phase_i,
  input  logic                         mc_en_i,
  input  logic [RANGE_W-1:0]           range_code_i,
  input  logic                         loop_full_i,
  input  logic                         locked_i,
  input  logic                         ne_dis_i,
  output logic signed [CNT_W+FRAC_W:0] phase_err_o,
  output logic                         near_edge_o,
  output logic                         cyc_ovf_o
);

  logic                    rst_sync_n;
  logic [CNT_W-1:0]        limit;
  logic signed [CNT_W-1:0] cnt_q;
  cap_mode_e               mode;

  mcpt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mcpt_range_decode #(.CNT_W(CNT_W), .RANGE_W(RANGE_W)) u_range (
    .code_i  (range_code_i),
    .limit_o (limit)
  );

  mcpt_cycle_counter #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en_i    (mc_en_i),
    .inc_i   (ref_edge_i),
    .dec_i   (fb_edge_i),
    .limit_i (limit),
    .cnt_o   (cnt_q),
    .ovf_o   (cyc_ovf_o)
  );

  mcpt_mode_sel u_mode (
    .mc_en_i     (mc_en_i),
    .loop_full_i (loop_full_i),
    .locked_i    (locked_i),
    .ne_dis_i    (ne_dis_i),
    .mode_o      (mode)
  );

  mcpt_phase_combine #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_comb (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mode_i  (mode),
    .cnt_i   (cnt_q),
    .fine_i  (fine_phase_i),
    .phase_o (phase_err_o),
    .near_o  (near_edge_o)
  );

endmodule

// File: rtl/mcpt_checker.sv
module mcpt_checker #(
  parameter int CNT_W  = 14,
  parameter int FRAC_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         mc_en,
  input logic                         locked,
  input logic                         ne_dis,
  input logic                         loop_full,
  input logic                         ref_edge,
  input logic                         fb_edge,
  input logic signed [CNT_W-1:0]      cnt,
  input logic [CNT_W-1:0]             limit,
  input logic                         ovf,
  input logic                         near,
  input logic signed [CNT_W+FRAC_W:0] phase
);

  localparam int OUT_W = CNT_W + FRAC_W + 1;
  localparam logic signed [OUT_W-1:0] UI_C   = OUT_W'(64'd1 << FRAC_W);
  localparam logic signed [OUT_W-1:0] HALF_C = OUT_W'(64'd1 << (FRAC_W - 1));

  logic signed [CNT_W:0] cnt_x, lim_x;
  logic                  in_lim;

  assign cnt_x  = $signed({cnt[CNT_W-1], cnt});
  assign lim_x  = $signed({1'b0, limit});
  assign in_lim = (cnt_x <= lim_x) && (cnt_x >= -lim_x);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_state_R1: assert (phase == '0 && !near && !ovf);
    end
  end

  assert_disabled_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mc_en) |-> (cnt == '0) && !ovf);

  assert_hold_when_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mc_en && (ref_edge == fb_edge) && in_lim) |-> $stable(cnt));

  assert_within_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mc_en) |-> (cnt_x <= $past(lim_x)) && (cnt_x >= -$past(lim_x)));

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mc_en && ovf) |-> ovf);

  assert_clamp_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mc_en && !loop_full) |-> (phase <= UI_C) && (phase >= -UI_C));

  assert_nearest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mc_en && locked && !ne_dis) |-> near && (phase <= HALF_C) && (phase >= -HALF_C));

  assert_ne_dis_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ne_dis) |-> !near);

endmodule

bind mcyc_phase_tracker mcpt_checker #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .mc_en     (mc_en_i),
  .locked    (locked_i),
  .ne_dis    (ne_dis_i),
  .loop_full (loop_full_i),
  .ref_edge  (ref_edge_i),
  .fb_edge   (fb_edge_i),
  .cnt       (cnt_q),
  .limit     (limit),
  .ovf       (cyc_ovf_o),
  .near      (near_edge_o),
  .phase     (phase_err_o)
);

// File: tb/mcyc_phase_tracker_test.sv
module mcyc_phase_tracker_test;

  localparam int CW   = 6;
  localparam int FW   = 4;
  localparam int RW   = 4;
  localparam int OW   = CW + FW + 1;
  localparam int UNIT = 1 << FW;
  localparam int HALF = 1 << (FW - 1);
  localparam int MAXC = CW - 2;

  logic                 clk;
  logic                 rst_n;
  logic                 ref_edge, fb_edge;
  logic signed [FW:0]   fine;
  logic                 mc_en, loop_full, locked, ne_dis;
  logic [RW-1:0]        code;
  logic signed [OW-1:0] phase;
  logic                 near, ovf;

  int nchk  = 0;
  int nfail = 0;
  int exp_cnt = 0;
  bit exp_ovf = 0;
  bit done = 0;

  mcyc_phase_tracker #(.CNT_W(CW), .FRAC_W(FW), .RANGE_W(RW)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_edge_i   (ref_edge),
    .fb_edge_i    (fb_edge),
    .fine_phase_i (fine),
    .mc_en_i      (mc_en),
    .range_code_i (code),
    .loop_full_i  (loop_full),
    .locked_i     (locked),
    .ne_dis_i     (ne_dis),
    .phase_err_o  (phase),
    .near_edge_o  (near),
    .cyc_ovf_o    (ovf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int lim_of(input int k);
    int e;
    e = (k > MAXC) ? MAXC : k;
    return (1 << (e + 1)) - 1;
  endfunction

  function automatic int exp_phase();
    int f, full;
    f = int'(fine);
    if (!mc_en) begin
      if (locked && !ne_dis) begin
        if (f > HALF) return f - UNIT;
        if (f < -HALF) return f + UNIT;
      end
      return f;
    end
    full = exp_cnt * UNIT + f;
    if (loop_full) return full;
    if (full > UNIT) return UNIT;
    if (full < -UNIT) return -UNIT;
    return full;
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic check_out(input string tag);
    cmp(tag, "phase_err", int'(phase), exp_phase());
    cmp(tag, "near_edge", int'(near), int'(!mc_en && locked && !ne_dis));
    cmp(tag, "ovf", int'(ovf), int'(exp_ovf));
  endtask

  // Called at a negedge; returns at the negedge after the output register has
  // captured the counter value produced by these strobes (R10 latency).
  task automatic drive(input logic r, input logic f);
    int s, l;
    ref_edge = r;
    fb_edge  = f;
    @(negedge clk);
    if (!mc_en) begin
      exp_cnt = 0;
      exp_ovf = 0;
    end else begin
      l = lim_of(int'(code));
      s = exp_cnt + ((r && !f) ? 1 : 0) - ((f && !r) ? 1 : 0);
      if (s > l) begin
        exp_cnt = l;
        exp_ovf = 1;
      end else if (s < -l) begin
        exp_cnt = -l;
        exp_ovf = 1;
      end else begin
        exp_cnt = s;
      end
    end
    ref_edge = 1'b0;
    fb_edge  = 1'b0;
    @(negedge clk);
  endtask

  task automatic fine_sweep(input string tag);
    for (int v = -UNIT; v < UNIT; v++) begin
      fine = (FW+1)'(v);
      drive(1'b0, 1'b0);
      check_out(tag);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    ref_edge = 1'b0; fb_edge = 1'b0; fine = '0;
    mc_en = 1'b0; loop_full = 1'b0; locked = 1'b0; ne_dis = 1'b0; code = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1", "phase_err", int'(phase), 0);
    cmp("R1", "near_edge", int'(near), 0);
    cmp("R1", "ovf", int'(ovf), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 and R9: disabled, unlocked, strobes present but count unused
    code = 4'd3;
    for (int i = 0; i < 6; i++) begin
      fine = (FW+1)'(i - 3);
      drive(1'b1, 1'b0);
      check_out("R2");
    end
    fine_sweep("R9");

    // R8: nearest-edge folding of every fine value
    locked = 1'b1;
    fine_sweep("R8");

    // R9: override keeps full capture while locked
    ne_dis = 1'b1;
    fine_sweep("R9");
    ne_dis = 1'b0;
    locked = 1'b0;

    // R3, R5, R6: per range code, saturate up and down with full loop value
    loop_full = 1'b1;
    fine = (FW+1)'(3);
    for (int k = 0; k < 16; k++) begin
      if (k == 7) k = 15;
      code = RW'(k);
      mc_en = 1'b0;
      drive(1'b0, 1'b0);
      check_out("R2");
      mc_en = 1'b1;
      for (int i = 0; i < lim_of(k) + 2; i++) begin
        drive(1'b1, 1'b0);
        check_out("R3");
      end
      for (int i = 0; i < 2 * lim_of(k) + 3; i++) begin
        drive(1'b0, 1'b1);
        check_out("R6");
      end
      // R5: ovf stays set after stepping back inside
      drive(1'b1, 1'b0);
      check_out("R5");
    end

    // R4: simultaneous strobes cancel
    code = 4'd2;
    mc_en = 1'b0;
    drive(1'b0, 1'b0);
    mc_en = 1'b1;
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b0);
    check_out("R4");
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 1'b1);
      check_out("R4");
    end

    // R6 and R7: fine sweeps at count +2, full then clamped
    fine_sweep("R6");
    loop_full = 1'b0;
    fine_sweep("R7");

    // R7: clamped while count ramps, full value returns when switched
    code = 4'd3;
    fine = -(FW+1)'(5);
    mc_en = 1'b0;
    drive(1'b0, 1'b0);
    mc_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      drive(1'b1, 1'b0);
      check_out("R7");
    end
    loop_full = 1'b1;
    drive(1'b0, 1'b0);
    check_out("R7");
    cmp("R7", "remembered", int'(phase), 10 * UNIT - 5);

    // R5: range shrink pulls count to the new bound and flags it
    code = 4'd1;
    drive(1'b0, 1'b0);
    check_out("R5");
    cmp("R5", "shrunk", int'(phase), 3 * UNIT - 5);
    // R2: disabling clears both count and flag
    mc_en = 1'b0;
    drive(1'b1, 1'b0);
    check_out("R2");
    mc_en = 1'b1;
    drive(1'b0, 1'b0);
    check_out("R2");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule